// File: doc/BRIEF.md
# Hourly Chime Tone Generator

This block drives a speaker pin with a square wave that marks the approach of each hour. It watches the BCD minute and second digits of a running 24-hour clock and a one-cycle pulse that marks each new second. In the last ten seconds of minute 59 it gives five short low-pitch beeps, one on each even second. It then gives a single high-pitch beep at the instant the clock rolls over to minute 00, second 00. Both pitches come from dividing the system clock. Timekeeping and display are handled elsewhere.

The time is examined only on a seconds tick. In the cycle where `sec_tick` is high, the digit inputs must already show the second that is being entered. A small state machine holds the pitch of the current second. It has three states: `CH_QUIET` (speaker low), `CH_LOW` (low pitch) and `CH_HIGH` (high pitch). On every tick it moves to one of these. It goes to `CH_HIGH` when the new time is 00:00, to `CH_LOW` when the new time is one of the five even chime seconds, and to `CH_QUIET` otherwise. This applies from every state: quiet to low, low to quiet, low to low, quiet to high, high to quiet, and so on. Without a tick, the state is held. Each tick that enters a beep restarts the tone divider, so every beep starts with the same phase.

Top module: `chime_tone_gen`

## Requirements
- R1: While `rst_n` is low, `spk_o` is 0. After reset the block is quiet until a matching tick arrives.
- R2: A tick whose digits read minute 59 with a second of 50, 52, 54, 56 or 58 starts a low beep. From the clock edge that samples the tick, `spk_o` is 1 for HALF_LO cycles, then 0 for HALF_LO cycles, and so on. HALF_LO = CLK_HZ/(2·LOW_HZ), which is 48,828 at 50 MHz and 512 Hz.
- R3: A tick whose digits read minute 00, second 00 starts a high beep with the same high-first shape and a half-period of HALF_HI = CLK_HZ/(2·HIGH_HZ). That is 24,414 at 50 MHz and 1024 Hz.
- R4: A tick into an odd second of minute 59 (51 to 59) leaves `spk_o` at 0 for that whole second.
- R5: A tick into any other time leaves `spk_o` at 0 until the next tick. Examples are 58:50, 59:48, 00:01 and 09:50.
- R6: A beep lasts until the next tick exactly. A non-matching tick sets `spk_o` to 0 at the edge that samples it, whatever the current phase.
- R7: A tick that starts a beep restarts the divider even if it falls on the same edge as a tone toggle. In that case `spk_o` is 1 after that edge and stays 1 for a full half-period.
- R8: Digit changes without a tick have no effect. While quiet the output stays 0. During a beep the pitch and phase continue unchanged.
- R9: The digits are 4-bit BCD values. A time with a digit outside its range (units above 9, tens above 5) never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| min_tens | input | 4 | Minute tens digit, BCD |
| min_ones | input | 4 | Minute units digit, BCD |
| sec_tens | input | 4 | Second tens digit, BCD |
| sec_ones | input | 4 | Second units digit, BCD |
| sec_tick | input | 1 | One-cycle pulse. The digits show the second being entered |
| spk_o | output | 1 | Square-wave speaker drive |

## Verification
A seconds tick that starts a beep can land on the same edge where the divider would toggle the tone. The restart and the toggle then compete for the same register. The bench provokes this by ending a low beep after exactly one half-period and issuing the next matching tick on that edge. The output must then be high and stay high for a full half-period, not drop low. A second collision is a non-matching tick during a high phase: the output must drop to 0 on that same edge.

// File: rtl/chime_pkg.sv
package chime_pkg;

    typedef enum logic [1:0] {
        CH_QUIET = 2'd0,
        CH_LOW   = 2'd1,
        CH_HIGH  = 2'd2
    } chime_state_e;

    function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                                input int unsigned tone_hz);
        return clk_hz / (2 * tone_hz);
    endfunction

endpackage

// File: rtl/chime_match.sv
module chime_match #(
    parameter int unsigned CHIME_MIN    = 59,
    parameter int unsigned LOW_BEEPS    = 5,
    parameter int unsigned LAST_LOW_SEC = 58
) (
    input  logic [3:0] min_tens,
    input  logic [3:0] min_ones,
    input  logic [3:0] sec_tens,
    input  logic [3:0] sec_ones,
    output logic       hit_low,
    output logic       hit_high
);
    localparam int unsigned FIRST_LOW_SEC = LAST_LOW_SEC - 2 * (LOW_BEEPS - 1);
    localparam logic        LOW_PARITY    = 1'(LAST_LOW_SEC % 2);

    logic       digits_ok;
    logic [7:0] min_val;
    logic [7:0] sec_val;

    always_comb begin
        digits_ok = (min_tens <= 4'd5) && (min_ones <= 4'd9) &&
                    (sec_tens <= 4'd5) && (sec_ones <= 4'd9);
        min_val   = {4'd0, min_tens} * 8'd10 + {4'd0, min_ones};
        sec_val   = {4'd0, sec_tens} * 8'd10 + {4'd0, sec_ones};
        hit_low   = digits_ok &&
                    (min_val == 8'(CHIME_MIN)) &&
                    (sec_val >= 8'(FIRST_LOW_SEC)) &&
                    (sec_val <= 8'(LAST_LOW_SEC)) &&
                    (sec_val[0] == LOW_PARITY);
        hit_high  = digits_ok && (min_val == 8'd0) && (sec_val == 8'd0);
    end

endmodule

// File: rtl/chime_divider.sv
module chime_divider #(
    parameter int unsigned HALF_LO = 48828,
    parameter int unsigned HALF_HI = 24414
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic sel_high,
    output logic tone
);
    localparam int unsigned HALF_MAX = (HALF_LO > HALF_HI) ? HALF_LO : HALF_HI;
    localparam int unsigned CW       = $clog2(HALF_MAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    always_comb begin
        limit = sel_high ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tone <= 1'b0;
        end else if (restart) begin
            cnt  <= '0;
            tone <= 1'b1;
        end else if (!run) begin
            cnt  <= '0;
            tone <= 1'b0;
        end else if (cnt == limit) begin
            cnt  <= '0;
            tone <= ~tone;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/chime_tone_gen.sv
module chime_tone_gen
    import chime_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 50_000_000,
    parameter int unsigned LOW_HZ       = 512,
    parameter int unsigned HIGH_HZ      = 1024,
    parameter int unsigned CHIME_MIN    = 59,
    parameter int unsigned LOW_BEEPS    = 5,
    parameter int unsigned LAST_LOW_SEC = 58
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] min_tens,
    input  logic [3:0] min_ones,
    input  logic [3:0] sec_tens,
    input  logic [3:0] sec_ones,
    input  logic       sec_tick,
    output logic       spk_o
);
    localparam int unsigned HALF_LO = half_cycles(CLK_HZ, LOW_HZ);
    localparam int unsigned HALF_HI = half_cycles(CLK_HZ, HIGH_HZ);

    chime_state_e state_q;
    chime_state_e state_nx;
    logic         hit_low;
    logic         hit_high;
    logic         div_restart;
    logic         div_run;
    logic         div_high;

    chime_match #(
        .CHIME_MIN    (CHIME_MIN),
        .LOW_BEEPS    (LOW_BEEPS),
        .LAST_LOW_SEC (LAST_LOW_SEC)
    ) u_match (
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones),
        .hit_low  (hit_low),
        .hit_high (hit_high)
    );

    // Next state: decided only on a seconds tick.
    always_comb begin
        state_nx = state_q;
        if (sec_tick) begin
            unique case (state_q)
                CH_QUIET, CH_LOW, CH_HIGH: begin
                    if (hit_high)      state_nx = CH_HIGH;
                    else if (hit_low)  state_nx = CH_LOW;
                    else               state_nx = CH_QUIET;
                end
                default: state_nx = CH_QUIET;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_QUIET;
        else        state_q <= state_nx;
    end

    // Output control: the divider follows the state being entered.
    always_comb begin
        div_restart = 1'b0;
        div_run     = 1'b0;
        div_high    = 1'b0;
        unique case (state_nx)
            CH_QUIET: ;
            CH_LOW: begin
                div_run     = 1'b1;
                div_restart = sec_tick;
            end
            CH_HIGH: begin
                div_run     = 1'b1;
                div_high    = 1'b1;
                div_restart = sec_tick;
            end
            default: ;
        endcase
    end

    chime_divider #(
        .HALF_LO (HALF_LO),
        .HALF_HI (HALF_HI)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (div_restart),
        .run      (div_run),
        .sel_high (div_high),
        .tone     (spk_o)
    );

endmodule

// File: rtl/chime_tone_chk.sv
module chime_tone_chk #(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned LOW_HZ = 512
) (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_ones,
    input logic       sec_tick,
    input logic       spk_o
);
    localparam int unsigned HALF_LO = CLK_HZ / (2 * LOW_HZ);

    logic        want_low;
    logic        want_high;
    logic        silent_q;
    logic [31:0] high_run_q;

    assign want_low  = (min_tens == 4'd5) && (min_ones == 4'd9) && (sec_tens == 4'd5) &&
                       ((sec_ones == 4'd0) || (sec_ones == 4'd2) || (sec_ones == 4'd4) ||
                        (sec_ones == 4'd6) || (sec_ones == 4'd8));
    assign want_high = (min_tens == 4'd0) && (min_ones == 4'd0) &&
                       (sec_tens == 4'd0) && (sec_ones == 4'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        silent_q <= 1'b1;
        else if (sec_tick) silent_q <= !(want_low || want_high);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   high_run_q <= '0;
        else if (spk_o && !sec_tick)  high_run_q <= high_run_q + 1'b1;
        else                          high_run_q <= '0;
    end

    // R2: a low chime second starts with the output high
    a_r2_low_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && want_low) |=> spk_o);

    // R3: the top of the hour starts with the output high
    a_r3_high_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && want_high) |=> spk_o);

    // R4: odd seconds of the chime minute are silent
    a_r4_odd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && min_tens == 4'd5 && min_ones == 4'd9 && sec_tens == 4'd5 &&
         sec_ones[0]) |=> !spk_o);

    // R5, R8: after a non-matching tick the output stays low until the next tick
    a_r5_silent_low: assert property (@(posedge clk) disable iff (!rst_n)
        silent_q |-> !spk_o);

    // R2: no high phase outlasts the longer half-period
    a_r2_high_phase_limit: assert property (@(posedge clk) disable iff (!rst_n)
        spk_o |-> (high_run_q < HALF_LO));

endmodule

bind chime_tone_gen chime_tone_chk #(
    .CLK_HZ (CLK_HZ),
    .LOW_HZ (LOW_HZ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .min_tens (min_tens),
    .min_ones (min_ones),
    .sec_tens (sec_tens),
    .sec_ones (sec_ones),
    .sec_tick (sec_tick),
    .spk_o    (spk_o)
);

// File: tb/chime_tone_gen_tb.sv
`timescale 1ns/1ps
module chime_tone_gen_tb;

    localparam int CLK_HZ  = 20480;
    localparam int HALF_LO = 20;
    localparam int HALF_HI = 10;
    localparam int SEC     = 60;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] min_tens = 4'd0;
    logic [3:0] min_ones = 4'd0;
    logic [3:0] sec_tens = 4'd0;
    logic [3:0] sec_ones = 4'd0;
    logic       sec_tick = 1'b0;
    logic       spk_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    chime_tone_gen #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones),
        .sec_tick (sec_tick),
        .spk_o    (spk_o)
    );

    // {min tens, min ones, sec tens, sec ones, kind}; kind 0 quiet, 1 low, 2 high
    localparam logic [17:0] VEC [0:17] = '{
        {4'd5, 4'd9, 4'd4, 4'd9, 2'd0},   // R5
        {4'd5, 4'd9, 4'd5, 4'd0, 2'd1},   // R2
        {4'd5, 4'd9, 4'd5, 4'd1, 2'd0},   // R4, R6
        {4'd5, 4'd9, 4'd5, 4'd2, 2'd1},
        {4'd5, 4'd9, 4'd5, 4'd3, 2'd0},
        {4'd5, 4'd9, 4'd5, 4'd4, 2'd1},
        {4'd5, 4'd9, 4'd5, 4'd5, 2'd0},
        {4'd5, 4'd9, 4'd5, 4'd6, 2'd1},
        {4'd5, 4'd9, 4'd5, 4'd7, 2'd0},
        {4'd5, 4'd9, 4'd5, 4'd8, 2'd1},
        {4'd5, 4'd9, 4'd5, 4'd9, 2'd0},
        {4'd0, 4'd0, 4'd0, 4'd0, 2'd2},   // R3
        {4'd0, 4'd0, 4'd0, 4'd1, 2'd0},
        {4'd5, 4'd8, 4'd5, 4'd0, 2'd0},   // R5: minute 58
        {4'd5, 4'd9, 4'd4, 4'd8, 2'd0},
        {4'd0, 4'd9, 4'd5, 4'd0, 2'd0},
        {4'd5, 4'd9, 4'd5, 4'd10, 2'd0},  // R9: bad units digit
        {4'd0, 4'd0, 4'd0, 4'd10, 2'd0}   // R9
    };

    function automatic logic expect_at(input int kind, input int k);
        int half;
        if (kind == 0) return 1'b0;
        half = (kind == 2) ? HALF_HI : HALF_LO;
        return ((k / half) % 2) == 0;
    endfunction

    // Called at a negedge: issues a tick with digits v and checks len samples.
    task automatic run_second(input logic [17:0] v, input int len,
                              input string req, input bit alt);
        int   kind;
        int   bad;
        logic got;
        logic exp;
        int   bad_k;
        logic bad_got;
        logic bad_exp;
        kind = int'(v[1:0]);
        bad  = 0;
        bad_k = 0; bad_got = 1'b0; bad_exp = 1'b0;
        {min_tens, min_ones, sec_tens, sec_ones} = v[17:2];
        sec_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sec_tick = 1'b0;
        if (alt) {min_tens, min_ones, sec_tens, sec_ones} = 16'h0000;
        for (int k = 0; k < len; k++) begin
            got = spk_o;
            exp = expect_at(kind, k);
            if (got !== exp && bad == 0) begin
                bad_k = k; bad_got = got; bad_exp = exp;
            end
            if (got !== exp) bad++;
            if (k < len - 1) @(negedge clk);
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s time %0d%0d:%0d%0d sample %0d actual %0b expected %0b",
                     req, v[17:14], v[13:10], v[9:6], v[5:2], bad_k, bad_got, bad_exp);
        end
    endtask

    task automatic check_bit(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual %0b expected %0b", req, got, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int bad;
        // R1: output low under reset and just after release
        repeat (3) @(negedge clk);
        check_bit(spk_o, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_bit(spk_o, 1'b0, "R1 after reset");

        // Table walk: R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 18; i++) begin
            run_second(VEC[i], SEC,
                       (VEC[i][1:0] == 2'd1) ? "R2" :
                       (VEC[i][1:0] == 2'd2) ? "R3" : "R4/R5/R9", 1'b0);
        end

        // R8: digits at a chime time without a tick while quiet
        {min_tens, min_ones, sec_tens, sec_ones} = 16'h5950;
        bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (spk_o !== 1'b0) bad++;
        end
        check_bit(bad == 0, 1'b1, "R8 quiet no tick");

        // R8: digits move to 00:00 mid low beep, pitch kept
        run_second({4'd5, 4'd9, 4'd5, 4'd0, 2'd1}, SEC, "R8 pitch kept", 1'b1);

        // R7: restart on the edge that would toggle low pitch
        run_second({4'd5, 4'd9, 4'd5, 4'd2, 2'd1}, HALF_LO, "R7 first", 1'b0);
        run_second({4'd5, 4'd9, 4'd5, 4'd4, 2'd1}, SEC, "R7 restart wins", 1'b0);

        // R7: same collision on the high pitch
        run_second({4'd0, 4'd0, 4'd0, 4'd0, 2'd2}, HALF_HI, "R7 high first", 1'b0);
        run_second({4'd0, 4'd0, 4'd0, 4'd0, 2'd2}, SEC, "R7 high restart", 1'b0);

        // R6: non-matching tick during a high phase ends the beep at once
        run_second({4'd5, 4'd9, 4'd5, 4'd6, 2'd1}, 5, "R6 start", 1'b0);
        run_second({4'd5, 4'd9, 4'd5, 4'd7, 2'd0}, 30, "R6 cut off", 1'b0);

        // R1: reset in the middle of a beep forces output low
        run_second({4'd5, 4'd9, 4'd5, 4'd8, 2'd1}, 5, "R1 pre", 1'b0);
        rst_n = 1'b0;
        #1;
        check_bit(spk_o, 1'b0, "R1 mid-beep reset");
        @(negedge clk);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        check_bit(spk_o, 1'b0, "R1 quiet after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule